// File: doc/BRIEF.md
# PCIe Interrupt Message Front-End

This block sits between an application's interrupt sources and the transmit side of a PCI Express transaction layer. It turns three kinds of interrupt request into message requests for a downstream TLP builder. A level-sensitive legacy interrupt status input is tracked. Its edges become INTx assert and deassert message requests, and the application gets an acknowledge once an assert message has gone out. An MSI request/acknowledge handshake carries a vector number and a traffic class. A second request/acknowledge pair carries the address and data of an MSI-X table entry and becomes a single-dword memory write. That write is released only while the MSI-X configuration bits allow it.

Every request is first latched into a pending slot. A small arbiter then picks one pending slot, with MSI first, then MSI-X, then legacy. It presents the pick on a valid/ready output whose fields stay frozen until the consumer accepts them. The legacy path keeps one pending message and remembers which INTx state the link last saw, so the messages always alternate.

Top module: `pcie_irq_front`

## Requirements
- R1: A rise of `intStatus` causes one message of type 2'b00 (assert INTx). With `txReady` high and the block idle, `txValid` carries it after the third rising clock edge that follows the change.
- R2: A fall of `intStatus` causes one message of type 2'b01 (deassert INTx).
- R3: `intAck` is high for exactly one cycle, in the cycle after a type 2'b00 message is accepted. It never rises for a deassert message.
- R4: At most one legacy message is pending. Edges that arrive while it waits are folded into the net level, so accepted legacy messages strictly alternate and two assert messages never follow each other.
- R5: `msiReq` is captured together with `msiVector` and `msiTc` and is sent as type 2'b10 with those values. `msiAck` pulses for one cycle after acceptance. A request still held during the acknowledge cycle is not taken as a new one.
- R6: An MSI-X request is sent as type 2'b11 carrying `msixAddr` and `msixData`, with `txFirstBe` = 4'b1111 and `txLastBe` = 4'b0000. `msixAck` pulses for one cycle after acceptance.
- R7: An MSI-X message is issued only while `msixEnable` is 1 and `msixFuncMask` is 0. A request made while gated stays pending and is issued once the gating opens.
- R8: While `txValid` is high and `txReady` is low, `txValid` and every payload field hold their values. Each acceptance consumes exactly one message.
- R9: When several requests are pending at the moment a message is chosen, MSI goes first, then MSI-X, then legacy.
- R10: A synchronous active-high `rst` clears all pending requests, the stored link INTx state and the acknowledge outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| intStatus | input | 1 | Legacy interrupt level from the application |
| intAck | output | 1 | Pulse: assert INTx message accepted |
| msiReq | input | 1 | MSI request, held until acknowledged |
| msiVector | input | 5 | MSI vector number, valid with msiReq |
| msiTc | input | 3 | MSI traffic class, valid with msiReq |
| msiAck | output | 1 | Pulse: MSI message accepted |
| msixReq | input | 1 | MSI-X request, held until acknowledged |
| msixAddr | input | 64 | MSI-X table entry address |
| msixData | input | 32 | MSI-X table entry data |
| msixEnable | input | 1 | MSI-X enable configuration bit |
| msixFuncMask | input | 1 | MSI-X function mask configuration bit |
| msixAck | output | 1 | Pulse: MSI-X message accepted |
| txValid | output | 1 | Message request valid |
| txReady | input | 1 | Downstream accepts the message |
| txType | output | 2 | 00 assert INTx, 01 deassert INTx, 10 MSI, 11 MSI-X |
| txVector | output | 5 | MSI vector number |
| txTc | output | 3 | MSI traffic class |
| txAddr | output | 64 | MSI-X write address |
| txData | output | 32 | MSI-X write data |
| txFirstBe | output | 4 | First-dword byte enable |
| txLastBe | output | 4 | Last-dword byte enable |

## Verification
Some properties are checked by assertions on every cycle. These are the frozen output while backpressured, the alternation of legacy message types against the stored link state, MSI-X release only under open gating, and the single-cycle acknowledge pulses. Other behaviour needs the directed scenarios to show it. These are the exact three-edge latency, how bursts of status edges fold while a message waits, the order chosen when several sources are pending together, that a gated MSI-X request survives until the gate opens, and that reset leaves nothing behind.

// File: rtl/pcie_irq_pkg.sv
package pcie_irq_pkg;
  typedef enum logic [1:0] {
    MSG_ASSERT   = 2'b00,
    MSG_DEASSERT = 2'b01,
    MSG_MSI      = 2'b10,
    MSG_MSIX     = 2'b11
  } msgType_e;

  typedef struct packed {
    logic     loadMsi;
    logic     loadMsix;
    msgType_e sel;
  } ctrlStrobe_t;
endpackage

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import pcie_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        intStatus,
  input  logic        msiReq,
  input  logic        msixReq,
  input  logic        msixEnable,
  input  logic        msixFuncMask,
  input  logic        txReady,
  output logic        txValid,
  output ctrlStrobe_t strobe,
  output logic        intAck,
  output logic        msiAck,
  output logic        msixAck
);
  logic statusQ, linkState, legPend, legIsAssert;
  logic msiPend, msixPend, curValid;
  msgType_e curSel, winner;
  logic anyEligible, msiCapture, msixCapture, msixGo, accept, curIsLeg;
  logic intAckQ, msiAckQ, msixAckQ;

  assign accept      = curValid && txReady;
  assign curIsLeg    = (curSel == MSG_ASSERT) || (curSel == MSG_DEASSERT);
  assign msiCapture  = msiReq && !msiPend && !msiAckQ;
  assign msixCapture = msixReq && !msixPend && !msixAckQ;
  assign msixGo      = msixPend && msixEnable && !msixFuncMask;

  always_comb begin
    anyEligible = 1'b1;
    if (msiPend)      winner = MSG_MSI;
    else if (msixGo)  winner = MSG_MSIX;
    else if (legPend) winner = legIsAssert ? MSG_ASSERT : MSG_DEASSERT;
    else begin
      winner      = MSG_ASSERT;
      anyEligible = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      statusQ     <= 1'b0;
      linkState   <= 1'b0;
      legPend     <= 1'b0;
      legIsAssert <= 1'b0;
      msiPend     <= 1'b0;
      msixPend    <= 1'b0;
      curValid    <= 1'b0;
      curSel      <= MSG_ASSERT;
      intAckQ     <= 1'b0;
      msiAckQ     <= 1'b0;
      msixAckQ    <= 1'b0;
    end else begin
      statusQ  <= intStatus;
      intAckQ  <= accept && (curSel == MSG_ASSERT);
      msiAckQ  <= accept && (curSel == MSG_MSI);
      msixAckQ <= accept && (curSel == MSG_MSIX);

      if (msiCapture) msiPend <= 1'b1;
      else if (accept && curSel == MSG_MSI) msiPend <= 1'b0;

      if (msixCapture) msixPend <= 1'b1;
      else if (accept && curSel == MSG_MSIX) msixPend <= 1'b0;

      if (accept && curIsLeg) begin
        legPend   <= 1'b0;
        linkState <= legIsAssert;
      end else if (!legPend && statusQ != linkState) begin
        legPend     <= 1'b1;
        legIsAssert <= statusQ;
      end

      if (accept) curValid <= 1'b0;
      else if (!curValid && anyEligible) begin
        curValid <= 1'b1;
        curSel   <= winner;
      end
    end
  end

  assign txValid       = curValid;
  assign strobe.loadMsi  = msiCapture;
  assign strobe.loadMsix = msixCapture;
  assign strobe.sel      = curSel;
  assign intAck  = intAckQ;
  assign msiAck  = msiAckQ;
  assign msixAck = msixAckQ;

  // R8
  hold_while_stalled_chk: assert property (@(posedge clk) disable iff (rst)
    curValid && !txReady |=> curValid && $stable(curSel));

  // R4
  assert_alternates_chk: assert property (@(posedge clk) disable iff (rst)
    curValid && curSel == MSG_ASSERT |-> !linkState);

  // R4
  deassert_alternates_chk: assert property (@(posedge clk) disable iff (rst)
    curValid && curSel == MSG_DEASSERT |-> linkState);

  // R7
  msix_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(curValid) && curSel == MSG_MSIX |-> $past(msixEnable && !msixFuncMask));

  // R3
  int_ack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    intAckQ |=> !intAckQ);

  // R5
  msi_ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    msiAckQ |-> !msiPend && !(curValid && curSel == MSG_MSI));

  // R6
  msix_ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    msixAckQ |-> !msixPend && !(curValid && curSel == MSG_MSIX));
endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import pcie_irq_pkg::*;
#(
  parameter int VEC_W  = 5,
  parameter int TC_W   = 3,
  parameter int ADDR_W = 64,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       strobe,
  input  logic [VEC_W-1:0]  msiVector,
  input  logic [TC_W-1:0]   msiTc,
  input  logic [ADDR_W-1:0] msixAddr,
  input  logic [DATA_W-1:0] msixData,
  input  logic              txValid,
  input  logic              txReady,
  output logic [VEC_W-1:0]  txVector,
  output logic [TC_W-1:0]   txTc,
  output logic [ADDR_W-1:0] txAddr,
  output logic [DATA_W-1:0] txData,
  output logic [3:0]        txFirstBe,
  output logic [3:0]        txLastBe
);
  localparam logic [3:0] FULL_BE  = 4'b1111;
  localparam logic [3:0] EMPTY_BE = 4'b0000;

  logic [VEC_W-1:0]  vecQ;
  logic [TC_W-1:0]   tcQ;
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      vecQ  <= '0;
      tcQ   <= '0;
      addrQ <= '0;
      dataQ <= '0;
    end else begin
      if (strobe.loadMsi) begin
        vecQ <= msiVector;
        tcQ  <= msiTc;
      end
      if (strobe.loadMsix) begin
        addrQ <= msixAddr;
        dataQ <= msixData;
      end
    end
  end

  always_comb begin
    txVector  = '0;
    txTc      = '0;
    txAddr    = '0;
    txData    = '0;
    txFirstBe = EMPTY_BE;
    txLastBe  = EMPTY_BE;
    case (strobe.sel)
      MSG_MSI: begin
        txVector = vecQ;
        txTc     = tcQ;
      end
      MSG_MSIX: begin
        txAddr    = addrQ;
        txData    = dataQ;
        txFirstBe = FULL_BE;
        txLastBe  = EMPTY_BE;
      end
      default: ;
    endcase
  end

  // R8
  payload_stable_chk: assert property (@(posedge clk) disable iff (rst)
    txValid && !txReady |=> $stable(txVector) && $stable(txTc)
                            && $stable(txAddr) && $stable(txData));
endmodule

// File: rtl/pcie_irq_front.sv
module pcie_irq_front
  import pcie_irq_pkg::*;
#(
  parameter int VEC_W  = 5,
  parameter int TC_W   = 3,
  parameter int ADDR_W = 64,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              intStatus,
  output logic              intAck,
  input  logic              msiReq,
  input  logic [VEC_W-1:0]  msiVector,
  input  logic [TC_W-1:0]   msiTc,
  output logic              msiAck,
  input  logic              msixReq,
  input  logic [ADDR_W-1:0] msixAddr,
  input  logic [DATA_W-1:0] msixData,
  input  logic              msixEnable,
  input  logic              msixFuncMask,
  output logic              msixAck,
  output logic              txValid,
  input  logic              txReady,
  output logic [1:0]        txType,
  output logic [VEC_W-1:0]  txVector,
  output logic [TC_W-1:0]   txTc,
  output logic [ADDR_W-1:0] txAddr,
  output logic [DATA_W-1:0] txData,
  output logic [3:0]        txFirstBe,
  output logic [3:0]        txLastBe
);
  ctrlStrobe_t strobe;

  irq_ctrl uCtrl (
    .clk(clk), .rst(rst), .intStatus(intStatus), .msiReq(msiReq),
    .msixReq(msixReq), .msixEnable(msixEnable), .msixFuncMask(msixFuncMask),
    .txReady(txReady), .txValid(txValid), .strobe(strobe),
    .intAck(intAck), .msiAck(msiAck), .msixAck(msixAck)
  );

  irq_datapath #(.VEC_W(VEC_W), .TC_W(TC_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rst(rst), .strobe(strobe), .msiVector(msiVector), .msiTc(msiTc),
    .msixAddr(msixAddr), .msixData(msixData), .txValid(txValid), .txReady(txReady),
    .txVector(txVector), .txTc(txTc), .txAddr(txAddr), .txData(txData),
    .txFirstBe(txFirstBe), .txLastBe(txLastBe)
  );

  assign txType = strobe.sel;
endmodule

// File: tb/pcie_irq_front_test.sv
module pcie_irq_front_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic intStatus = 1'b0, msiReq = 1'b0, msixReq = 1'b0;
  logic [4:0] msiVector = '0;
  logic [2:0] msiTc = '0;
  logic [63:0] msixAddr = '0;
  logic [31:0] msixData = '0;
  logic msixEnable = 1'b0, msixFuncMask = 1'b0, txReady = 1'b0;
  logic intAck, msiAck, msixAck, txValid;
  logic [1:0] txType;
  logic [4:0] txVector;
  logic [2:0] txTc;
  logic [63:0] txAddr;
  logic [31:0] txData;
  logic [3:0] txFirstBe, txLastBe;

  pcie_irq_front uut (
    .clk(clk), .rst(rst), .intStatus(intStatus), .intAck(intAck),
    .msiReq(msiReq), .msiVector(msiVector), .msiTc(msiTc), .msiAck(msiAck),
    .msixReq(msixReq), .msixAddr(msixAddr), .msixData(msixData),
    .msixEnable(msixEnable), .msixFuncMask(msixFuncMask), .msixAck(msixAck),
    .txValid(txValid), .txReady(txReady), .txType(txType), .txVector(txVector),
    .txTc(txTc), .txAddr(txAddr), .txData(txData),
    .txFirstBe(txFirstBe), .txLastBe(txLastBe)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int nCmp = 0, nErr = 0, cyc = 0;
  int logCnt = 0, intAckCnt = 0, msiAckCnt = 0, msixAckCnt = 0, intAckCyc = 0;
  logic [1:0]  logType [16];
  logic [4:0]  logVec  [16];
  logic [2:0]  logTc   [16];
  logic [63:0] logAddr [16];
  logic [31:0] logData [16];
  logic [3:0]  logFbe  [16];
  logic [3:0]  logLbe  [16];
  int          logCyc  [16];
  logic msiSeen = 1'b0, msixSeen = 1'b0, done = 1'b0;

  // Monitor at the falling edge: inputs change just after rising edges.
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (txValid && txReady && logCnt < 16) begin
        logType[logCnt] = txType;  logVec[logCnt] = txVector; logTc[logCnt] = txTc;
        logAddr[logCnt] = txAddr;  logData[logCnt] = txData;
        logFbe[logCnt]  = txFirstBe; logLbe[logCnt] = txLastBe; logCyc[logCnt] = cyc;
        logCnt++;
      end
      if (intAck) begin intAckCnt++; intAckCyc = cyc; end
      if (msiAck) msiAckCnt++;
      if (msixAck) msixAckCnt++;
    end
  end

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      if (msiSeen) msiReq = 1'b0;
      msiSeen = msiAck;
      if (msixSeen) msixReq = 1'b0;
      msixSeen = msixAck;
    end
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nCmp++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearLog();
    logCnt = 0; intAckCnt = 0; msiAckCnt = 0; msixAckCnt = 0;
  endtask

  task automatic testReset();
    rst = 1'b1; tick(3); rst = 1'b0;
    check("R10 txValid after reset", txValid, 0);
    check("R10 acks after reset", {intAck, msiAck, msixAck}, 0);
  endtask

  task automatic testLegacyBasic();
    int c0;
    clearLog(); txReady = 1'b1;
    c0 = cyc; intStatus = 1'b1; tick(8);
    check("R1 one message", logCnt, 1);
    check("R1 type assert", logType[0], 2'b00);
    check("R1 latency", logCyc[0] - c0, 4);
    check("R3 intAck count", intAckCnt, 1);
    check("R3 intAck cycle", intAckCyc - c0, 5);
    intStatus = 1'b0; tick(8);
    check("R2 one more message", logCnt, 2);
    check("R2 type deassert", logType[1], 2'b01);
    check("R3 no ack on deassert", intAckCnt, 1);
  endtask

  task automatic testLegacyFold();
    clearLog(); txReady = 1'b0;
    intStatus = 1'b1; tick(4); intStatus = 1'b0; tick(4);
    check("R8 held while stalled", {txValid, txType}, {1'b1, 2'b00});
    txReady = 1'b1; tick(10);
    check("R4 pair count", logCnt, 2);
    check("R4 first assert", logType[0], 2'b00);
    check("R4 then deassert", logType[1], 2'b01);
    clearLog(); txReady = 1'b0;
    intStatus = 1'b1; tick(4); intStatus = 1'b0; tick(2); intStatus = 1'b1; tick(4);
    txReady = 1'b1; tick(10);
    check("R4 folded to one", logCnt, 1);
    check("R4 folded type", logType[0], 2'b00);
    intStatus = 1'b0; tick(8);
    check("R4 deassert follows", logType[1], 2'b01);
    check("R4 total", logCnt, 2);
  endtask

  task automatic testMsi();
    clearLog(); txReady = 1'b0;
    msiVector = 5'd19; msiTc = 3'd5; msiReq = 1'b1; tick(5);
    check("R5 valid while stalled", {txValid, txType}, {1'b1, 2'b10});
    check("R5 vector shown", {txVector, txTc}, {5'd19, 3'd5});
    txReady = 1'b1; tick(8);
    check("R5 one MSI", logCnt, 1);
    check("R5 type", logType[0], 2'b10);
    check("R5 vector/tc", {logVec[0], logTc[0]}, {5'd19, 3'd5});
    check("R5 ack once", msiAckCnt, 1);
    check("R5 request dropped", msiReq, 0);
  endtask

  task automatic testMsix();
    clearLog(); txReady = 1'b1;
    msixEnable = 1'b1; msixFuncMask = 1'b1;
    msixAddr = 64'hFEE0_0000_1234_5670; msixData = 32'hCAFE_0042; msixReq = 1'b1;
    tick(10);
    check("R7 masked not issued", logCnt, 0);
    check("R7 masked no valid", txValid, 0);
    msixFuncMask = 1'b0; tick(10);
    check("R7 issued after unmask", logCnt, 1);
    check("R6 type", logType[0], 2'b11);
    check("R6 addr", logAddr[0], 64'hFEE0_0000_1234_5670);
    check("R6 data", logData[0], 32'hCAFE_0042);
    check("R6 byte enables", {logFbe[0], logLbe[0]}, 8'hF0);
    check("R6 ack once", msixAckCnt, 1);
    clearLog(); msixEnable = 1'b0;
    msixAddr = 64'h1000; msixData = 32'h7; msixReq = 1'b1; tick(10);
    check("R7 disabled not issued", logCnt, 0);
    msixEnable = 1'b1; tick(10);
    check("R7 issued after enable", logCnt, 1);
    check("R7 data kept", logData[0], 32'h7);
  endtask

  task automatic testPriority();
    clearLog(); txReady = 1'b0;
    intStatus = 1'b1; tick(1);
    msiVector = 5'd7; msiTc = 3'd2; msiReq = 1'b1;
    msixAddr = 64'h2000; msixData = 32'h99; msixReq = 1'b1;
    tick(6); txReady = 1'b1; tick(15);
    check("R9 count", logCnt, 3);
    check("R9 first MSI", logType[0], 2'b10);
    check("R9 second MSI-X", logType[1], 2'b11);
    check("R9 last legacy", logType[2], 2'b00);
    intStatus = 1'b0; tick(8);
    check("R2 cleanup deassert", logType[3], 2'b01);
  endtask

  task automatic testMidReset();
    clearLog(); txReady = 1'b0;
    intStatus = 1'b1; msiVector = 5'd1; msiReq = 1'b1; tick(5);
    check("R10 pending before reset", txValid, 1);
    rst = 1'b1; intStatus = 1'b0; msiReq = 1'b0; tick(2); rst = 1'b0; tick(1);
    check("R10 cleared valid", txValid, 0);
    txReady = 1'b1; tick(8);
    check("R10 nothing left", logCnt, 0);
  endtask

  initial begin
    testReset();
    testLegacyBasic();
    testLegacyFold();
    testMsi();
    testMsix();
    testPriority();
    testMidReset();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nErr);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nCmp++; nErr++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nErr);
      $finish;
    end
  end
endmodule